// File: doc/BRIEF.md
# Sleep-State Power and Wake Controller

This block records which sleep level the system is in and drives three external power-plane control lines for that level. Software chooses a level by writing a sleep-type field together with a sleep-enable strobe. The block then leaves the working state S0 and enters one of the levels SL1 to SL5.

A vector of power-management event inputs is watched all the time. Each event has its own enable bit and its own sticky status bit. If an enabled event arrives while the system is asleep, the hardware returns the system to S0 by itself and sets a sticky wake flag. Any enabled event whose status bit is still set holds an interrupt line high. A global select bit steers that interrupt to SCI or to SMI. A few event classes can only ever produce SCI.

Software reaches the status, enable and control registers through a small register port. Writes are registered. Reads are combinational.

Top module: `slp_pwr_wake_ctl`

## Requirements
- R1: Reset puts the block in S0, with all enable bits, status bits, the wake flag and the select bit cleared, `pwr_ctl_a`=1, `pwr_ctl_b`=1, `on_ctl_n`=0, and `sci`=`smi`=0.
- R2: The power outputs follow the state held in the previous cycle. Encoding the levels S0, SL1 to SL5 as 0 to 5: `pwr_ctl_a` is 1 for states 0 and 1, `pwr_ctl_b` is 1 for states 0 to 2, and `on_ctl_n` is 1 only for states 4 and 5.
- R3: The state leaves S0 only on a write to address 0x0C with bit 4 (the strobe) set. The new state is then the field in bits [3:1]. A field value of 0, 6 or 7 leaves the state unchanged.
- R4: When an event arrives while asleep and its enable bit is set, the state becomes S0 at the next edge. The same edge sets the wake flag, which is bit 15 of address 0x08. In that cycle this wake has priority over a sleep write.
- R5: An event whose enable bit is clear does not wake the system. Its status bit is still set.
- R6: The event status bits sit at address 0x08 in bits [N_EVT-1:0], and so does the wake flag. Writing a 1 to one of these bits clears it. If an event arrives in the same cycle as the clear, the bit stays set.
- R7: An event that arrives in S0 sets its status bit but changes neither the state nor the wake flag.
- R8: When the select bit (address 0x0C bit 0) is 1, `sci` is high exactly while some status bit and its enable bit are both set, and `smi` stays low.
- R9: When the select bit is 0, `smi` is high exactly while a pending enabled event outside the SCI-only mask exists. `sci` is high exactly while a pending enabled event inside the mask exists. With the default mask, bits 1, 2 and 11 are the SCI-only events.
- R10: Address 0x0A reads and writes the enable bits [N_EVT-1:0]. Address 0x0C reads back the select bit in bit 0 and the current state in bits [3:1], and reads 0 in bit 4. Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | N_EVT | Power-management event inputs, sampled every cycle |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| pwr_ctl_a | output | 1 | First power-plane control, high in S0 and SL1 |
| pwr_ctl_b | output | 1 | Second power-plane control, high in S0 to SL2 |
| on_ctl_n | output | 1 | Active-low on-control, high in SL4 and SL5 |
| sci | output | 1 | SCI request level |
| smi | output | 1 | SMI request level |

## Verification
Several rules are checked by assertions on every cycle:
- the one-cycle lag between the state and the power-output map;
- the hardware wake and the wake flag it sets;
- status bits that cannot drop without a write-one;
- the S0 exit rule;
- the SCI/SMI steering, including the SCI-only classes.

Other cases are shown only by the bench's scenarios, where a cycle-based reference model is compared with every output and register read. These are the ignored sleep-type codes, a disabled event arriving during sleep, an event colliding with a clear, and the round trip through every sleep level.

// File: rtl/slp_pwr_wake_ctl.sv
module slp_pwr_wake_ctl #(
  parameter int N_EVT = 12,
  parameter logic [N_EVT-1:0] SCI_ONLY = 12'h806
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic [7:0]       reg_addr,
  input  logic             reg_we,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             pwr_ctl_a,
  output logic             pwr_ctl_b,
  output logic             on_ctl_n,
  output logic             sci,
  output logic             smi
);
  localparam logic [7:0] A_STS = 8'h08, A_EN = 8'h0A, A_CTL = 8'h0C;

  logic [2:0]       state;
  logic [N_EVT-1:0] sts, en;
  logic             wak, sci_sel;

  wire wr_sts = reg_we && reg_addr == A_STS;
  wire wr_en  = reg_we && reg_addr == A_EN;
  wire wr_ctl = reg_we && reg_addr == A_CTL;
  wire [2:0] req_lvl = reg_wdata[3:1];
  wire sleep_go = wr_ctl && reg_wdata[4] && req_lvl != 3'd0 && req_lvl <= 3'd5;
  wire wake = state != 3'd0 && |(evt_in & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= 3'd0;
      sts     <= '0;
      en      <= '0;
      wak     <= 1'b0;
      sci_sel <= 1'b0;
    end else begin
      sts <= (sts & ~(wr_sts ? reg_wdata[N_EVT-1:0] : '0)) | evt_in;
      if (wake) wak <= 1'b1;
      else if (wr_sts && reg_wdata[15]) wak <= 1'b0;
      if (wr_en) en <= reg_wdata[N_EVT-1:0];
      if (wr_ctl) sci_sel <= reg_wdata[0];
      if (wake) state <= 3'd0;
      else if (sleep_go) state <= req_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_ctl_a <= 1'b1;
      pwr_ctl_b <= 1'b1;
      on_ctl_n  <= 1'b0;
    end else begin
      pwr_ctl_a <= state <= 3'd1;
      pwr_ctl_b <= state <= 3'd2;
      on_ctl_n  <= state >= 3'd4;
    end
  end

  wire [N_EVT-1:0] pend = sts & en;
  assign sci = sci_sel ? |pend : |(pend & SCI_ONLY);
  assign smi = !sci_sel && |(pend & ~SCI_ONLY);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STS: begin
        reg_rdata[N_EVT-1:0] = sts;
        reg_rdata[15] = wak;
      end
      A_EN:  reg_rdata[N_EVT-1:0] = en;
      A_CTL: reg_rdata[3:0] = {state, sci_sel};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module slp_pwr_wake_chk #(
  parameter int N_EVT = 12,
  parameter logic [N_EVT-1:0] SCI_ONLY = 12'h806
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] evt_in,
  input logic [7:0]       reg_addr,
  input logic             reg_we,
  input logic [15:0]      reg_wdata,
  input logic [2:0]       state,
  input logic [N_EVT-1:0] sts,
  input logic [N_EVT-1:0] en,
  input logic             wak,
  input logic             sci_sel,
  input logic             pwr_ctl_a,
  input logic             pwr_ctl_b,
  input logic             on_ctl_n,
  input logic             sci,
  input logic             smi
);
  p_pwr_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pwr_ctl_a == ($past(state) < 3'd2)) && (pwr_ctl_b == ($past(state) < 3'd3))
             && (on_ctl_n == ($past(state) > 3'd3)));

  p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 3'd0 && |(evt_in & en)) |=> (state == 3'd0 && wak));

  p_leave_s0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && !(reg_we && reg_addr == 8'h0C && reg_wdata[4])) |=> state == 3'd0);

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 8'h08) |=> ((sts & $past(sts)) == $past(sts)));

  p_sci_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sci_sel |-> (!smi && sci == |(sts & en)));

  p_sci_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts & en & ~SCI_ONLY)) == 1'b0 |-> !smi);
endmodule

bind slp_pwr_wake_ctl slp_pwr_wake_chk #(.N_EVT(N_EVT), .SCI_ONLY(SCI_ONLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .state(state), .sts(sts), .en(en), .wak(wak), .sci_sel(sci_sel),
  .pwr_ctl_a(pwr_ctl_a), .pwr_ctl_b(pwr_ctl_b), .on_ctl_n(on_ctl_n), .sci(sci), .smi(smi));

// File: tb/test_slp_pwr_wake_ctl.sv
module test_slp_pwr_wake_ctl;
  localparam logic [11:0] ONLY = 12'h806;
  logic clk = 0, rst_n = 0;
  logic [11:0] evt_in = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic pwr_ctl_a, pwr_ctl_b, on_ctl_n, sci, smi;

  slp_pwr_wake_ctl i_slp_pwr_wake_ctl (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  string req = "R1";
  int m_state = 0;
  logic [11:0] m_sts = 0, m_en = 0;
  bit m_wak = 0, m_sel = 0, m_a = 1, m_b = 1, m_on = 0;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", r, act, exp, cyc);
    end
  endtask

  function automatic int exp_rd();
    case (reg_addr)
      8'h08: return {m_wak, 3'b0, m_sts};
      8'h0A: return {4'b0, m_en};
      8'h0C: return (m_state << 1) | m_sel;
      default: return 0;
    endcase
  endfunction

  task automatic compare();
    logic [11:0] p;
    p = m_sts & m_en;
    chk({req, "/R2 pwr_ctl_a"}, pwr_ctl_a, m_a);
    chk({req, "/R2 pwr_ctl_b"}, pwr_ctl_b, m_b);
    chk({req, "/R2 on_ctl_n"}, on_ctl_n, m_on);
    chk({req, "/R8/R9 sci"}, sci, m_sel ? |p : |(p & ONLY));
    chk({req, "/R8/R9 smi"}, smi, !m_sel && |(p & ~ONLY));
    chk({req, "/R10 rdata"}, reg_rdata, exp_rd());
  endtask

  task automatic step(logic [11:0] e, bit we, logic [7:0] a, logic [15:0] d);
    int old;
    bit wk;
    evt_in = e; reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    old = m_state;
    wk = (m_state != 0) && |(e & m_en);
    if (we && a == 8'h08) begin
      m_sts &= ~d[11:0];
      if (d[15]) m_wak = 0;
    end
    m_sts |= e;
    if (wk) m_wak = 1;
    if (wk) m_state = 0;
    else if (we && a == 8'h0C && d[4] && d[3:1] >= 1 && d[3:1] <= 5) m_state = d[3:1];
    if (we && a == 8'h0A) m_en = d[11:0];
    if (we && a == 8'h0C) m_sel = d[0];
    m_a = old <= 1; m_b = old <= 2; m_on = old >= 4;
    #2 compare();
    @(negedge clk);
  endtask

  task automatic idle(int n, logic [7:0] a);
    for (int i = 0; i < n; i++) step('0, 0, a, '0);
  endtask

  function automatic logic [15:0] slp(int lvl, bit sel);
    return 16'h0010 | 16'(lvl << 1) | 16'(sel);
  endfunction

  initial begin
    #23;
    req = "R1"; compare();
    @(negedge clk) rst_n = 1;
    idle(2, 8'h0C);
    idle(1, 8'h08);
    // R10 enable and select writes
    req = "R10";
    step('0, 1, 8'h0A, 16'h000F);
    step('0, 1, 8'h0C, 16'h0001);
    idle(1, 8'h0A);
    step('0, 1, 8'h0C, 16'h0001);
    idle(1, 8'h44);
    // R7 events while in S0
    req = "R7";
    step(12'h020, 0, 8'h08, 0);
    step(12'h001, 0, 8'h08, 0);
    idle(2, 8'h0C);
    // R6 write-one-to-clear, and set colliding with clear
    req = "R6";
    step('0, 1, 8'h08, 16'h0020);
    idle(1, 8'h08);
    step(12'h001, 1, 8'h08, 16'h0001);
    idle(1, 8'h08);
    step('0, 1, 8'h08, 16'h0001);
    idle(1, 8'h08);
    // R3 ignored sleep types keep S0
    req = "R3";
    step('0, 1, 8'h0C, slp(0, 1));
    step('0, 1, 8'h0C, slp(6, 1));
    step('0, 1, 8'h0C, slp(7, 1));
    step('0, 1, 8'h0C, 16'h0007);
    idle(2, 8'h0C);
    // R3/R2 enter SL3
    step('0, 1, 8'h0C, slp(3, 1));
    idle(3, 8'h0C);
    // R5 disabled event does not wake
    req = "R5";
    step(12'h080, 0, 8'h0C, 0);
    idle(2, 8'h08);
    // R4 enabled event wakes
    req = "R4";
    step(12'h008, 0, 8'h0C, 0);
    idle(2, 8'h08);
    step('0, 1, 8'h08, 16'h8088);
    idle(1, 8'h08);
    // R9 select=0, SMI and SCI-only classes
    req = "R9";
    step('0, 1, 8'h0A, 16'h0807);
    step('0, 1, 8'h0C, 16'h0000);
    step(12'h001, 0, 8'h08, 0);
    idle(1, 8'h08);
    step(12'h002, 0, 8'h08, 0);
    step('0, 1, 8'h08, 16'h0001);
    idle(1, 8'h08);
    step(12'h800, 0, 8'h08, 0);
    step('0, 1, 8'h08, 16'h0802);
    idle(1, 8'h08);
    // R8 switch back to SCI with pending event
    req = "R8";
    step(12'h004, 1, 8'h0C, 16'h0001);
    idle(1, 8'h08);
    step('0, 1, 8'h08, 16'h0004);
    idle(1, 8'h08);
    // R2/R4 every level round trip, wake beats sleep write
    req = "R2";
    for (int l = 1; l <= 5; l++) begin
      step('0, 1, 8'h0C, slp(l, 1));
      idle(2, 8'h0C);
      step(12'h001, 1, 8'h0C, slp(5, 1));
      idle(2, 8'h0C);
      step('0, 1, 8'h08, 16'h8FFF);
    end
    // R4 level change while asleep, then wake
    req = "R4";
    step('0, 1, 8'h0C, slp(2, 1));
    step('0, 1, 8'h0C, slp(5, 1));
    idle(2, 8'h0C);
    step(12'h800, 0, 8'h0C, 0);
    idle(2, 8'h08);
    summary();
  end
endmodule